// File: doc/BRIEF.md
# Key-Gated Configuration Register Bank

This block holds the configuration words of a display controller. A simple single-cycle read/write port addresses them, and every stored word drives one flat output bus for the logic that uses the settings. Twelve of the nineteen words are guarded: the raster timing words, the attribute word and the line-carry word. A guarded word only takes a write when the access just before it was a write of the key value to the lock word. The unguarded words (brightness, pixel mode and the five frame-memory words) take writes at any time.

An unlock is one-shot. The next access of any kind ends it: a read, a write, or an access to an address with nothing behind it. That access is itself still served under the unlock. Cycles with no access leave the unlock pending. A write to a guarded word while the bank is locked is dropped and raises a sticky violation flag. The flag can be read back from the lock word.

Top module: `keyed_regbank`

## Requirements
- R1: After reset the bank is locked, the violation flag is clear, every word on `reg_image` is zero, and a read of the lock word returns 0.
- R2: The unguarded words take writes whether the bank is locked or not: brightness 0x020, frame page 0x028, half page 0x02C, line count 0x030, line length 0x034, line step 0x038, pixel mode 0x054.
- R3: A write of exactly 0x000000AA to the lock word at 0x07C unlocks the bank. A read of the lock word returns bit 0 = 1 while unlocked and bit 1 = violation flag, with all other bits 0. A key write while unlocked re-arms the unlock.
- R4: The guarded words are 0x000–0x01C (eight words), 0x024, 0x03C, 0x228 and 0x22C. A write to one of them is stored when it is the access directly after a key write.
- R5: Any access that is not a key write locks the bank again, whatever its kind or address. A guarded write that follows such an access is dropped.
- R6: A guarded-word write while locked, or a write of any non-key value to the lock word while locked, leaves all words unchanged and sets the sticky violation flag.
- R7: A non-key write to the lock word while unlocked clears the violation flag and locks the bank. Nothing else clears the flag except reset.
- R8: A read returns its data on `rd_data` with `rd_valid` high in the cycle after the request. Unmapped and unaligned addresses read as zero, and writes to them change no word.
- R9: `reg_image` holds word k in bits [32k+31:32k], with k running over 0x000, 0x004, 0x008, 0x00C, 0x010, 0x014, 0x018, 0x01C, 0x228, 0x22C, 0x024, 0x03C, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x054.
- R10: Cycles without an access do not consume a pending unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| reg_image | output | 608 | All stored words, packed per R9 |

## Verification
Two functions can fall in the same cycle. The access that spends an unlock can also be the guarded write that uses it, so the store and the relock happen together. A key write can also land while the bank is already unlocked, so consumption and re-arming coincide. The bench provokes both with back-to-back accesses: key then guarded write, and key then key then guarded write. It judges the result by the stored word on `reg_image` and by a later read of the lock word, with expected values from its own model of the requirements.

// File: rtl/kb_pkg.sv
package kb_pkg;
  localparam int NREG      = 19;
  localparam int N_GUARDED = 12;
  localparam int OFS_W     = 12;

  // Byte offset of word k; the order of k is the order on the image bus.
  function automatic logic [OFS_W-1:0] reg_offset(input int idx);
    if (idx < 8) return OFS_W'(idx * 4);
    case (idx)
      8:       return 12'h228;
      9:       return 12'h22C;
      10:      return 12'h024;
      11:      return 12'h03C;
      12:      return 12'h020;
      18:      return 12'h054;
      default: return OFS_W'(32'h28 + (idx - 13) * 4);
    endcase
  endfunction

  // Words with index below N_GUARDED need the key.
  function automatic logic [NREG-1:0] guard_mask();
    logic [NREG-1:0] m;
    m = '0;
    for (int i = 0; i < NREG; i++) m[i] = (i < N_GUARDED);
    return m;
  endfunction
endpackage

// File: rtl/kb_decode.sv
module kb_decode
  import kb_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] LOCK_OFS = 'h07C
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            lock_hit,
  output logic            guarded_hit
);
  localparam logic [NREG-1:0] GMASK = guard_mask();

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign hit[g] = (addr == AW'(reg_offset(g)));
  end

  assign lock_hit    = (addr == LOCK_OFS);
  assign guarded_hit = |(hit & GMASK);
endmodule

// File: rtl/kb_gate.sv
module kb_gate #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          wr,
  input  logic          lock_hit,
  input  logic          guarded_hit,
  input  logic [DW-1:0] wdata,
  output logic          unlocked,
  output logic          err
);
  logic key_val, ev_key, ev_violation, ev_clear;

  assign key_val      = (wdata == KEY);
  assign ev_key       = acc && wr && lock_hit && key_val;
  assign ev_violation = acc && wr && !unlocked && (guarded_hit || (lock_hit && !key_val));
  assign ev_clear     = acc && wr && unlocked && lock_hit && !key_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (acc) unlocked <= ev_key;
      if (ev_violation)  err <= 1'b1;
      else if (ev_clear) err <= 1'b0;
    end
  end

  a_r3_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ev_key |=> unlocked);
  a_r5_access_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ev_key) |=> !unlocked);
  a_r10_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(unlocked));
  a_r6_violation_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_violation |=> err);
  a_r7_only_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ev_clear) |=> err);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (!err && !unlocked));
endmodule

// File: rtl/kb_store.sv
module kb_store
  import kb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    we,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] image
);
  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (we[g]) q[g] <= wdata;
    end

    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> $stable(q[g]));
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) image[k*DW +: DW] = q[k];
  end
endmodule

// File: rtl/keyed_regbank.sv
module keyed_regbank
  import kb_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 'hAA,
  parameter logic [AW-1:0] LOCK_OFS = 'h07C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_wdata,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] reg_image
);
  localparam logic [NREG-1:0] GMASK = guard_mask();

  logic [NREG-1:0] hit, we;
  logic            lock_hit, guarded_hit, unlocked, err;
  logic            rd_req, guarded_drop;
  logic [DW-1:0]   rd_mux;

  kb_decode #(.AW(AW), .LOCK_OFS(LOCK_OFS)) u_dec (
    .addr(acc_addr), .hit(hit), .lock_hit(lock_hit), .guarded_hit(guarded_hit)
  );

  kb_gate #(.DW(DW), .KEY(KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .acc(acc_valid), .wr(acc_write),
    .lock_hit(lock_hit), .guarded_hit(guarded_hit), .wdata(acc_wdata),
    .unlocked(unlocked), .err(err)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = acc_valid && acc_write && hit[g] && (!GMASK[g] || unlocked);
  end

  kb_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(acc_wdata), .image(reg_image)
  );

  assign rd_req       = acc_valid && !acc_write;
  assign guarded_drop = acc_valid && acc_write && guarded_hit && !unlocked;

  always_comb begin
    rd_mux = '0;
    if (lock_hit) rd_mux = {{(DW-2){1'b0}}, err, unlocked};
    for (int k = 0; k < NREG; k++)
      if (hit[k]) rd_mux = reg_image[k*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, lock_hit}));
  a_r8_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r6_drop_keeps_image: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_drop |=> $stable(reg_image));
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_drop |=> err);
endmodule

// File: tb/sim_keyed_regbank.sv
module sim_keyed_regbank;
  localparam int NR = 19;
  localparam logic [11:0] LOCKA = 12'h07C;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NR*32-1:0] reg_image;

  int checks = 0, failures = 0;
  logic [31:0] exp_r [NR];
  bit m_unl = 0, m_err = 0;

  always #10 clk = ~clk;

  keyed_regbank u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .reg_image(reg_image)
  );

  function automatic logic [11:0] off_of(int i);
    if (i < 8)   return 12'(4 * i);
    if (i == 8)  return 12'h228;
    if (i == 9)  return 12'h22C;
    if (i == 10) return 12'h024;
    if (i == 11) return 12'h03C;
    if (i == 12) return 12'h020;
    if (i == 18) return 12'h054;
    return 12'(12'h028 + 4 * (i - 13));
  endfunction

  function automatic bit prot_of(int i);
    return i < 12;
  endfunction

  function automatic int idx_of(logic [11:0] a);
    for (int i = 0; i < NR; i++) if (off_of(i) == a) return i;
    return -1;
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_image(string req);
    for (int k = 0; k < NR; k++) check32(req, reg_image[k*32 +: 32], exp_r[k]);
  endtask

  task automatic do_acc(bit wr, logic [11:0] a, logic [31:0] d, string req);
    logic [31:0] exp_rd;
    int k;
    bit kw;
    k = idx_of(a);
    kw = wr && (a == LOCKA) && (d == 32'h0000_00AA);
    exp_rd = '0;
    if (!wr) begin
      if (a == LOCKA) exp_rd = {30'b0, m_err, m_unl};
      else if (k >= 0) exp_rd = exp_r[k];
    end else if (a == LOCKA) begin
      if (!kw) begin
        if (m_unl) m_err = 0;
        else m_err = 1;
      end
    end else if (k >= 0) begin
      if (!prot_of(k) || m_unl) exp_r[k] = d;
      else m_err = 1;
    end
    m_unl = kw;
    acc_valid = 1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    if (!wr) begin
      check32(req, {31'b0, rd_valid}, 32'd1);
      check32(req, rd_data, exp_rd);
    end
    check_image(req);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) exp_r[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R9 layout of zeros
    check_image("R1");
    check32("R1", {31'b0, rd_valid}, 32'd0);
    do_acc(0, LOCKA, 0, "R1");

    // Sweep every word: locked write, readback, keyed write, lock status, clear
    for (int i = 0; i < NR; i++) begin
      logic [31:0] d1, d2;
      d1 = 32'h1357_0000 ^ (32'h0101_0101 * (i + 1));
      d2 = ~d1;
      do_acc(1, off_of(i), d1, prot_of(i) ? "R6" : "R2");
      do_acc(0, off_of(i), 0, "R9");
      do_acc(0, LOCKA, 0, "R6");
      if (prot_of(i)) begin
        do_acc(1, LOCKA, 32'hAA, "R3");
        do_acc(1, off_of(i), d2, "R4");
        do_acc(0, LOCKA, 0, "R5");
        do_acc(1, LOCKA, 32'hAA, "R3");
        do_acc(1, LOCKA, 32'h0, "R7");
        do_acc(0, LOCKA, 0, "R7");
      end else begin
        do_acc(1, off_of(i), d2, "R2");
      end
      do_acc(0, off_of(i), 0, "R9");
    end

    // R5: a read consumes the unlock
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(0, off_of(12), 0, "R5");
    do_acc(1, off_of(0), 32'hDEAD_0001, "R5");
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(1, LOCKA, 32'h1, "R7");

    // R5/R8: unmapped access consumes the unlock and stores nothing
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(1, 12'h100, 32'hFFFF_FFFF, "R8");
    do_acc(1, off_of(1), 32'hDEAD_0002, "R5");
    do_acc(0, 12'h100, 0, "R8");
    do_acc(0, 12'h07D, 0, "R8");
    do_acc(1, 12'h07D, 32'hAA, "R8");
    do_acc(1, off_of(2), 32'hDEAD_0003, "R8");
    do_acc(0, LOCKA, 0, "R6");

    // R10: idle cycles keep the unlock; the read that sees it consumes it
    do_acc(1, LOCKA, 32'hAA, "R10");
    idle(5);
    do_acc(0, LOCKA, 0, "R10");
    do_acc(0, LOCKA, 0, "R10");

    // R3: re-arm by a second key write, then a guarded write lands
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(1, off_of(9), 32'hC0DE_0009, "R3");
    do_acc(0, off_of(9), 0, "R4");

    // R7 clear, then R6 non-key value to the lock word while locked
    do_acc(1, LOCKA, 32'hAA, "R3");
    do_acc(1, LOCKA, 32'h5, "R7");
    do_acc(0, LOCKA, 0, "R7");
    do_acc(1, LOCKA, 32'h1AA, "R6");
    do_acc(0, LOCKA, 0, "R6");
    do_acc(1, off_of(15), 32'h0000_0777, "R2");
    do_acc(0, LOCKA, 0, "R6");

    idle(2);
    check32("R8", {31'b0, rd_valid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule